// File: doc/BRIEF.md
# Temperature Limit Alert Logic

This block judges each finished temperature conversion against an upper and a lower limit. It keeps a sticky flag for each side, drives an alert pin whose active level is programmable, and records whether the latest out-of-window event was on the hot side or the cold side, so that an alert-response transaction can report it. Samples and limits are 12-bit two's-complement numbers with a resolution of 1/16 degree per count.

Two alert behaviours are selectable. In comparator mode, each flag follows the temperature with a programmable dead band: it sets as soon as the limit is crossed and drops only once the sample is back inside the limit by the hysteresis amount. The alert is active while either flag is set. In interrupt mode, a limit event latches the flags and the alert. The alert is then cleared by a configuration-register read, a successful alert response or a general-call reset, and each of these three clear sources treats the flags and the pin differently. The serial bus and the conversion sequencing around the block supply the strobes.

Top module: `temp_limit_alert`

## Requirements
- R1: After reset both flags and the over/under indicator are 0 and the alert is inactive (alert_o is 1 with pol_i=0).
- R2: A comparison happens only in the cycle where smp_vld_i is 1, and its result is visible at the outputs in the next cycle. A signed sample strictly greater than lim_hi_i sets flag_hi_o, and one strictly less than lim_lo_i sets flag_lo_o. A sample equal to a limit sets nothing.
- R3: In interrupt mode (irq_mode_i=1) a limit event makes the alert active, and it stays active through any number of later in-window samples.
- R4: In interrupt mode, cfg_rd_i clears both flags and the alert. If a limit event arrives in the same cycle, the new event wins.
- R5: In interrupt mode, ack_clr_i makes the alert inactive and leaves both flags unchanged.
- R6: gc_rst_i clears both flags, the alert and the over/under indicator in either mode, and overrides a sample in the same cycle.
- R7: In comparator mode (irq_mode_i=0) flag_hi_o sets when the sample is above lim_hi_i and clears when the sample is below lim_hi_i minus the hysteresis; otherwise it holds. flag_lo_o sets below lim_lo_i and clears above lim_lo_i plus the hysteresis. The alert is active exactly while a flag is set, and cfg_rd_i and ack_clr_i have no effect.
- R8: hys_sel_i codes 0, 1, 2 and 3 select a hysteresis of 0, 16, 32 and 64 counts (0, 1, 2 and 4 degrees). The shifted release thresholds saturate at -2048 and +2047 and never wrap.
- R9: With pol_i=0 the alert is active low on alert_o. With pol_i=1 it is active high.
- R10: On a conversion, over_o becomes 1 if the sample is above lim_hi_i, and otherwise becomes 0 if it is below lim_lo_i; otherwise it holds. A sample that is above the upper limit and below the lower limit at once sets both flags and gives over_o=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_i | input | 12 | Conversion result, two's complement |
| smp_vld_i | input | 1 | Conversion-done strobe |
| lim_hi_i | input | 12 | Upper limit |
| lim_lo_i | input | 12 | Lower limit |
| irq_mode_i | input | 1 | 1 = latched interrupt mode, 0 = comparator mode |
| hys_sel_i | input | 2 | Hysteresis code |
| pol_i | input | 1 | Alert polarity, 1 = active high |
| cfg_rd_i | input | 1 | Configuration-register read strobe |
| ack_clr_i | input | 1 | Successful alert-response strobe |
| gc_rst_i | input | 1 | General-call reset strobe |
| flag_hi_o | output | 1 | Over-limit flag |
| flag_lo_o | output | 1 | Under-limit flag |
| alert_o | output | 1 | Alert pin level |
| over_o | output | 1 | Cause of the last event: 1 = hot side, 0 = cold side |

## Verification
The bench builds the block at its default width of 12 bits with 16 counts per degree. This puts the full signed range, from 0x800 to 0x7FF, within reach of directed samples, so release thresholds that would wrap without clamping, such as a lower limit of 2040 plus 64 counts, are exercised at the real rails. The same setting lets every hysteresis code be probed exactly one count either side of its release point.

// File: rtl/temp_alert_pkg.sv
package temp_alert_pkg;

    typedef struct packed {
        logic fh;
        logic fl;
        logic act;
        logic ovr;
    } tal_state_t;

    // Multiplier of the per-degree count for each hysteresis code
    function automatic logic [2:0] hys_mult(input logic [1:0] code);
        case (code)
            2'd0:    return 3'd0;
            2'd1:    return 3'd1;
            2'd2:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/tal_hys_window.sv
module tal_hys_window #(
    parameter int TW       = 12,
    parameter int HYS_UNIT = 16
) (
    input  logic [TW-1:0] lim_hi_i,
    input  logic [TW-1:0] lim_lo_i,
    input  logic [1:0]    hys_sel_i,
    output logic [TW-1:0] rel_hi_o,
    output logic [TW-1:0] rel_lo_o
);
    import temp_alert_pkg::*;

    localparam int EW = TW + $clog2(HYS_UNIT + 1) + 4;
    localparam logic signed [EW-1:0] MIN_X = EW'(-(2 ** (TW - 1)));
    localparam logic signed [EW-1:0] MAX_X = EW'((2 ** (TW - 1)) - 1);

    logic signed [EW-1:0] ofs_x;
    logic signed [EW-1:0] hi_x;
    logic signed [EW-1:0] lo_x;
    logic signed [EW-1:0] hi_shift;
    logic signed [EW-1:0] lo_shift;

    always_comb begin
        ofs_x    = EW'(HYS_UNIT) * EW'(hys_mult(hys_sel_i));
        hi_x     = EW'($signed(lim_hi_i));
        lo_x     = EW'($signed(lim_lo_i));
        hi_shift = hi_x - ofs_x;
        lo_shift = lo_x + ofs_x;
        rel_hi_o = (hi_shift < MIN_X) ? MIN_X[TW-1:0] : hi_shift[TW-1:0];
        rel_lo_o = (lo_shift > MAX_X) ? MAX_X[TW-1:0] : lo_shift[TW-1:0];
    end

    // R8: the clamped release thresholds never move outward past their limits
    always_comb begin
        if (!$isunknown({lim_hi_i, lim_lo_i, hys_sel_i})) begin
            a_r8_rel_hi_inside: assert ($signed(rel_hi_o) <= $signed(lim_hi_i));
            a_r8_rel_lo_inside: assert ($signed(rel_lo_o) >= $signed(lim_lo_i));
        end
    end

endmodule

// File: rtl/tal_compare.sv
module tal_compare #(
    parameter int TW    = 12,
    parameter bit UPPER = 1'b1
) (
    input  logic [TW-1:0] smp_i,
    input  logic [TW-1:0] lim_i,
    input  logic [TW-1:0] rel_i,
    output logic          trip_o,
    output logic          back_o
);
    generate
        if (UPPER) begin : g_upper
            assign trip_o = $signed(smp_i) > $signed(lim_i);
            assign back_o = $signed(smp_i) < $signed(rel_i);
        end else begin : g_lower
            assign trip_o = $signed(smp_i) < $signed(lim_i);
            assign back_o = $signed(smp_i) > $signed(rel_i);
        end
    endgenerate

endmodule

// File: rtl/tal_state.sv
module tal_state (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       smp_vld_i,
    input  logic                       trip_hi_i,
    input  logic                       trip_lo_i,
    input  logic                       back_hi_i,
    input  logic                       back_lo_i,
    input  logic                       irq_mode_i,
    input  logic                       cfg_rd_i,
    input  logic                       ack_clr_i,
    input  logic                       gc_rst_i,
    output temp_alert_pkg::tal_state_t st_o
);
    import temp_alert_pkg::*;

    tal_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (irq_mode_i) begin
            if (cfg_rd_i) begin
                st_d.fh  = 1'b0;
                st_d.fl  = 1'b0;
                st_d.act = 1'b0;
            end
            if (ack_clr_i) st_d.act = 1'b0;
            if (smp_vld_i) begin
                if (trip_hi_i) st_d.fh = 1'b1;
                if (trip_lo_i) st_d.fl = 1'b1;
                if (trip_hi_i || trip_lo_i) st_d.act = 1'b1;
            end
        end else begin
            if (smp_vld_i) begin
                if (trip_hi_i)      st_d.fh = 1'b1;
                else if (back_hi_i) st_d.fh = 1'b0;
                if (trip_lo_i)      st_d.fl = 1'b1;
                else if (back_lo_i) st_d.fl = 1'b0;
            end
            st_d.act = st_d.fh | st_d.fl;
        end
        if (smp_vld_i) begin
            if (trip_hi_i)      st_d.ovr = 1'b1;
            else if (trip_lo_i) st_d.ovr = 1'b0;
        end
        if (gc_rst_i) st_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign st_o = st_q;

    a_r2_no_rise_without_sample: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_vld_i |=> (!$rose(st_q.fh) && !$rose(st_q.fl)));

    a_r5_ack_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_mode_i && ack_clr_i && !cfg_rd_i && !gc_rst_i && !smp_vld_i)
        |=> (!st_q.act && $stable(st_q.fh) && $stable(st_q.fl)));

    a_r6_gc_clears_all: assert property (@(posedge clk) disable iff (!rst_n)
        gc_rst_i |=> (!st_q.fh && !st_q.fl && !st_q.act && !st_q.ovr));

    a_r7_comp_holds_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_mode_i && !smp_vld_i && !gc_rst_i) |=> ($stable(st_q.fh) && $stable(st_q.fl)));

    a_r10_over_on_high: assert property (@(posedge clk) disable iff (!rst_n)
        (smp_vld_i && trip_hi_i && !gc_rst_i) |=> st_q.ovr);

endmodule

// File: rtl/temp_limit_alert.sv
module temp_limit_alert #(
    parameter int TW       = 12,
    parameter int HYS_UNIT = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [TW-1:0] smp_i,
    input  logic          smp_vld_i,
    input  logic [TW-1:0] lim_hi_i,
    input  logic [TW-1:0] lim_lo_i,
    input  logic          irq_mode_i,
    input  logic [1:0]    hys_sel_i,
    input  logic          pol_i,
    input  logic          cfg_rd_i,
    input  logic          ack_clr_i,
    input  logic          gc_rst_i,
    output logic          flag_hi_o,
    output logic          flag_lo_o,
    output logic          alert_o,
    output logic          over_o
);
    import temp_alert_pkg::*;

    localparam int NSIDE = 2;  // index 0 = upper side, 1 = lower side

    logic [NSIDE-1:0][TW-1:0] lim_w;
    logic [NSIDE-1:0][TW-1:0] rel_w;
    logic [NSIDE-1:0]         trip_w;
    logic [NSIDE-1:0]         back_w;
    tal_state_t               st_w;

    assign lim_w[0] = lim_hi_i;
    assign lim_w[1] = lim_lo_i;

    tal_hys_window #(.TW(TW), .HYS_UNIT(HYS_UNIT)) u_win (
        .lim_hi_i (lim_hi_i),
        .lim_lo_i (lim_lo_i),
        .hys_sel_i(hys_sel_i),
        .rel_hi_o (rel_w[0]),
        .rel_lo_o (rel_w[1])
    );

    for (genvar g = 0; g < NSIDE; g++) begin : g_side
        tal_compare #(.TW(TW), .UPPER(g == 0)) u_cmp (
            .smp_i (smp_i),
            .lim_i (lim_w[g]),
            .rel_i (rel_w[g]),
            .trip_o(trip_w[g]),
            .back_o(back_w[g])
        );
    end

    tal_state u_st (
        .clk       (clk),
        .rst_n     (rst_n),
        .smp_vld_i (smp_vld_i),
        .trip_hi_i (trip_w[0]),
        .trip_lo_i (trip_w[1]),
        .back_hi_i (back_w[0]),
        .back_lo_i (back_w[1]),
        .irq_mode_i(irq_mode_i),
        .cfg_rd_i  (cfg_rd_i),
        .ack_clr_i (ack_clr_i),
        .gc_rst_i  (gc_rst_i),
        .st_o      (st_w)
    );

    assign flag_hi_o = st_w.fh;
    assign flag_lo_o = st_w.fl;
    assign over_o    = st_w.ovr;
    assign alert_o   = pol_i ? st_w.act : ~st_w.act;

    // R9: the pin follows the active state through the selected polarity
    a_r9_pol_high: assert property (@(posedge clk) disable iff (!rst_n)
        (pol_i && !(flag_hi_o || flag_lo_o) && !irq_mode_i) |-> !alert_o);

endmodule

// File: tb/tb_temp_limit_alert.sv
module tb_temp_limit_alert;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] smp_i = '0;
    logic        smp_vld_i = 1'b0;
    logic [11:0] lim_hi_i = 12'h7FF;
    logic [11:0] lim_lo_i = 12'h800;
    logic        irq_mode_i = 1'b1;
    logic [1:0]  hys_sel_i = 2'd1;
    logic        pol_i = 1'b0;
    logic        cfg_rd_i = 1'b0;
    logic        ack_clr_i = 1'b0;
    logic        gc_rst_i = 1'b0;
    logic        flag_hi_o, flag_lo_o, alert_o, over_o;

    int errors = 0;
    int checks = 0;
    string cur_req = "R1";
    bit done = 1'b0;

    int m_fh = 0, m_fl = 0, m_act = 0, m_ovr = 0;

    always #10 clk = ~clk;

    temp_limit_alert dut (
        .clk(clk), .rst_n(rst_n), .smp_i(smp_i), .smp_vld_i(smp_vld_i),
        .lim_hi_i(lim_hi_i), .lim_lo_i(lim_lo_i), .irq_mode_i(irq_mode_i),
        .hys_sel_i(hys_sel_i), .pol_i(pol_i), .cfg_rd_i(cfg_rd_i),
        .ack_clr_i(ack_clr_i), .gc_rst_i(gc_rst_i), .flag_hi_o(flag_hi_o),
        .flag_lo_o(flag_lo_o), .alert_o(alert_o), .over_o(over_o)
    );

    function automatic int sx(input logic [11:0] v);
        return int'($signed(v));
    endfunction

    function automatic int hys_counts(input logic [1:0] c);
        int d;
        d = (c == 2'd3) ? 4 : int'(c);
        return d * 16;
    endfunction

    // Behavioural reference, stepped on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_fh = 0; m_fl = 0; m_act = 0; m_ovr = 0;
        end else begin
            int s, hi, lo, rhi, rlo;
            bit up, dn;
            s   = sx(smp_i);
            hi  = sx(lim_hi_i);
            lo  = sx(lim_lo_i);
            rhi = hi - hys_counts(hys_sel_i);
            rlo = lo + hys_counts(hys_sel_i);
            if (rhi < -2048) rhi = -2048;
            if (rlo > 2047)  rlo = 2047;
            up = s > hi;
            dn = s < lo;
            if (irq_mode_i) begin
                if (cfg_rd_i) begin m_fh = 0; m_fl = 0; m_act = 0; end
                if (ack_clr_i) m_act = 0;
                if (smp_vld_i) begin
                    if (up) m_fh = 1;
                    if (dn) m_fl = 1;
                    if (up || dn) m_act = 1;
                end
            end else begin
                if (smp_vld_i) begin
                    if (up) m_fh = 1; else if (s < rhi) m_fh = 0;
                    if (dn) m_fl = 1; else if (s > rlo) m_fl = 0;
                end
                m_act = (m_fh != 0 || m_fl != 0) ? 1 : 0;
            end
            if (smp_vld_i) begin
                if (up) m_ovr = 1; else if (dn) m_ovr = 0;
            end
            if (gc_rst_i) begin m_fh = 0; m_fl = 0; m_act = 0; m_ovr = 0; end
        end
    end

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Every-cycle comparison against the reference
    always @(negedge clk) begin
        if (rst_n && !done) begin
            int exp_pin;
            exp_pin = pol_i ? m_act : (m_act != 0 ? 0 : 1);
            chk(cur_req, "model flag_hi", int'(flag_hi_o), m_fh);
            chk(cur_req, "model flag_lo", int'(flag_lo_o), m_fl);
            chk(cur_req, "model over", int'(over_o), m_ovr);
            chk(cur_req, "model alert", int'(alert_o), exp_pin);
        end
    end

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic conv(input logic [11:0] v);
        smp_i = v; smp_vld_i = 1'b1;
        tick();
        smp_vld_i = 1'b0;
    endtask

    task automatic pulse_cfg();  cfg_rd_i = 1'b1;  tick(); cfg_rd_i = 1'b0;  endtask
    task automatic pulse_ack();  ack_clr_i = 1'b1; tick(); ack_clr_i = 1'b0; endtask
    task automatic pulse_gc();   gc_rst_i = 1'b1;  tick(); gc_rst_i = 1'b0;  endtask

    task automatic look(input string req, input int fh, input int fl, input int pin, input int ov);
        @(negedge clk);
        #1;
        chk(req, "flag_hi", int'(flag_hi_o), fh);
        chk(req, "flag_lo", int'(flag_lo_o), fl);
        chk(req, "alert_o", int'(alert_o), pin);
        chk(req, "over_o", int'(over_o), ov);
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        // R1 reset state
        cur_req = "R1";
        look("R1", 0, 0, 1, 0);

        // R2 default extreme window: nothing trips
        cur_req = "R2";
        conv(12'h190); look("R2", 0, 0, 1, 0);
        lim_hi_i = 12'h320; lim_lo_i = 12'h000;
        conv(12'h320); look("R2", 0, 0, 1, 0);      // equal to limit
        tick(); look("R2", 0, 0, 1, 0);            // no strobe
        conv(12'h321); look("R2", 1, 0, 0, 1);

        // R3 latched through in-window samples
        cur_req = "R3";
        conv(12'h190); conv(12'h000); look("R3", 1, 0, 0, 1);

        // R5 alert response clears pin only
        cur_req = "R5";
        pulse_ack(); look("R5", 1, 0, 1, 1);

        // R4 configuration read clears flags; same-cycle event wins
        cur_req = "R4";
        pulse_cfg(); look("R4", 0, 0, 1, 1);
        conv(12'hE70); look("R4", 0, 1, 0, 0);
        cfg_rd_i = 1'b1; conv(12'h400); cfg_rd_i = 1'b0;
        look("R4", 1, 0, 0, 1);

        // R6 general-call reset overrides a same-cycle sample
        cur_req = "R6";
        gc_rst_i = 1'b1; conv(12'h7F0); gc_rst_i = 1'b0;
        look("R6", 0, 0, 1, 0);

        // R9 polarity
        cur_req = "R9";
        pol_i = 1'b1; tick(); look("R9", 0, 0, 0, 0);
        conv(12'h500); look("R9", 1, 0, 1, 1);
        pol_i = 1'b0; tick(); look("R9", 1, 0, 0, 1);

        // R7/R8 comparator mode, upper side, each hysteresis code
        cur_req = "R7";
        irq_mode_i = 1'b0; pulse_gc();
        hys_sel_i = 2'd1;
        conv(12'h330); look("R7", 1, 0, 0, 1);
        pulse_cfg(); pulse_ack(); look("R7", 1, 0, 0, 1);
        cur_req = "R8";
        conv(12'h310); look("R8", 1, 0, 0, 1);     // hi-16, not below
        conv(12'h30F); look("R8", 0, 0, 1, 1);
        hys_sel_i = 2'd0;
        conv(12'h321); conv(12'h320); look("R8", 1, 0, 0, 1);
        conv(12'h31F); look("R8", 0, 0, 1, 1);
        hys_sel_i = 2'd2;
        conv(12'h321); conv(12'h300); look("R8", 1, 0, 0, 1);
        conv(12'h2FF); look("R8", 0, 0, 1, 1);
        hys_sel_i = 2'd3;
        conv(12'h321); conv(12'h2E0); look("R8", 1, 0, 0, 1);
        conv(12'h2DF); look("R8", 0, 0, 1, 1);

        // R7 lower side
        cur_req = "R7";
        conv(12'hFFF); look("R7", 0, 1, 0, 0);
        conv(12'h040); look("R7", 0, 1, 0, 0);
        conv(12'h041); look("R7", 0, 0, 1, 0);

        // R8 saturation at both rails
        cur_req = "R8";
        lim_hi_i = 12'h7FF; lim_lo_i = 12'h7F8;
        conv(12'h7D0); conv(12'h7FF); look("R8", 0, 1, 0, 0);
        lim_hi_i = 12'h808; lim_lo_i = 12'h800; pulse_gc();
        conv(12'h810); conv(12'h800); look("R8", 1, 0, 0, 1);

        // R10 misprogrammed window: both flags, high side wins
        cur_req = "R10";
        irq_mode_i = 1'b1; pulse_gc();
        lim_hi_i = 12'h000; lim_lo_i = 12'h100;
        conv(12'h080); look("R10", 1, 1, 0, 1);
        lim_hi_i = 12'h7FF; lim_lo_i = 12'h000;
        conv(12'hF00); look("R10", 1, 1, 0, 0);

        repeat (2) tick();
        finish_run();
    end

endmodule